// File: doc/BRIEF.md
# Soft-Start Timing Sequencer

This block produces the digital start-up timing for a voltage-mode switching regulator controller. It watches two qualifying flags: a supply power-good indication and the output of the enable/shutdown comparator. While either flag is false it holds the converter inhibited with gate drive blocked. Once both are true together it steps through three timed phases. The first is a quiet settling wait. The second asserts a strobe that discharges the compensation network. The third ramps a reference-offset code from full scale down to zero, and switching is permitted during this ramp. When the code reaches zero the block reports completion and remains in its run phase.

The offset code is meant to be subtracted from the feedback reference by an external converter, so the regulated target rises smoothly from zero to its final value. If either qualifying flag is lost in any phase, the block falls back to the inhibited phase and the whole sequence restarts from the beginning.

Top module: `softstart_seq`

## Requirements
- R1: While the qualified condition is false, phase_o reads 0 (hold). In this phase inhibit_o is 1, switch_en_o is 0, discharge_o is 0, done_o is 0 and offset_o is full scale (2047 with the default 11-bit width).
- R2: The hold phase is left only when pgood_i and enable_i are both 1 in the same cycles. If only one of them is 1, the block stays in phase 0 indefinitely.
- R3: After leaving hold, phase_o reads 1 (settle) for exactly 1024 clock cycles. During settle, inhibit_o, discharge_o and switch_en_o are all 0.
- R4: After settle, phase_o reads 2 and discharge_o is 1 for exactly 24 consecutive cycles, with switch_en_o 0.
- R5: After discharge, phase_o reads 3 (ramp) and switch_en_o is 1. In its first cycle offset_o equals full scale (2047), and it then falls by exactly 1 per cycle. The ramp phase lasts 2048 cycles, and its last cycle shows offset_o = 0.
- R6: After the ramp, phase_o reads 4 (run), done_o is 1, switch_en_o is 1 and offset_o is 0. These values hold for as long as both inputs stay 1.
- R7: If either input falls to 0 in any phase, the block returns to phase 0 with offset_o at full scale. When the inputs qualify again, the full sequence restarts from settle.
- R8: Each input passes through a two-flop synchronizer. A change applied between edges therefore reaches phase_o at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-derived clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pgood_i | input | 1 | Supply power-good flag (asynchronous) |
| enable_i | input | 1 | Enable/shutdown comparator flag (asynchronous) |
| phase_o | output | 3 | Current phase: 0 hold, 1 settle, 2 discharge, 3 ramp, 4 run |
| inhibit_o | output | 1 | Converter held in reset |
| discharge_o | output | 1 | Compensation-discharge strobe |
| switch_en_o | output | 1 | Gate drive / switching permitted |
| offset_o | output | 11 | Reference-offset code |
| done_o | output | 1 | Soft start complete |

## Verification
The hardest cases to reach from the ports are aborts that land deep inside a long phase. Examples are a loss of enable in the middle of the 24-cycle discharge window, or a loss of power-good partway down the 2048-step ramp. In these cases the offset must snap back to full scale and the sequence must start over. The stimulus reaches each phase by waiting on phase_o and then dropping one input a chosen number of cycles later. A behavioural model with its own synchronizer delay queue is compared on every clock, so every abort point is checked for both its latency and the restart that follows.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [2:0] {
    PH_HOLD   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_DISCH  = 3'd2,
    PH_RAMP   = 3'd3,
    PH_RUN    = 3'd4
  } phase_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ss_phase_ctrl.sv
module ss_phase_ctrl
  import softstart_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1024,
  parameter int DISCH_CYCLES  = 24
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ok_i,
  input  logic   ramp_zero_i,
  output phase_e phase_o
);
  localparam int CNT_MAX = (SETTLE_CYCLES > DISCH_CYCLES) ? SETTLE_CYCLES : DISCH_CYCLES;
  localparam int CNT_W   = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DISCH_LAST  = CNT_W'(DISCH_CYCLES - 1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    if (!ok_i) begin
      state_d = PH_HOLD;
    end else begin
      unique case (state_q)
        PH_HOLD:   state_d = PH_SETTLE;
        PH_SETTLE: if (cnt_q == SETTLE_LAST) state_d = PH_DISCH;
        PH_DISCH:  if (cnt_q == DISCH_LAST)  state_d = PH_RAMP;
        PH_RAMP:   if (ramp_zero_i)          state_d = PH_RUN;
        PH_RUN:    state_d = PH_RUN;
        default:   state_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)                              cnt_q <= '0;
      else if (state_q == PH_SETTLE || state_q == PH_DISCH) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = state_q;

  AST_ABORT_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_i |=> state_q == PH_HOLD); // R7
  AST_HOLD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PH_HOLD |=> (state_q == PH_HOLD || state_q == PH_SETTLE)); // R2
  AST_DISCH_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PH_DISCH |-> cnt_q <= DISCH_LAST); // R4
  AST_SETTLE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PH_SETTLE |-> cnt_q <= SETTLE_LAST); // R3
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_RUN && ok_i) |=> state_q == PH_RUN); // R6
endmodule

// File: rtl/ss_offset_ramp.sv
module ss_offset_ramp #(
  parameter int OFS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  output logic [OFS_W-1:0] offset_o,
  output logic             zero_o
);
  localparam logic [OFS_W-1:0] FULL = '1;

  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ofs_q <= FULL;
    else if (load_i)                ofs_q <= FULL;
    else if (dec_i && ofs_q != '0)  ofs_q <= ofs_q - 1'b1;
  end

  assign offset_o = ofs_q;
  assign zero_o   = (ofs_q == '0);

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o); // R6
  AST_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ofs_q <= $past(ofs_q)); // R5
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1024,
  parameter int DISCH_CYCLES  = 24,
  parameter int OFS_W         = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pgood_i,
  input  logic             enable_i,
  output logic [2:0]       phase_o,
  output logic             inhibit_o,
  output logic             discharge_o,
  output logic             switch_en_o,
  output logic [OFS_W-1:0] offset_o,
  output logic             done_o
);
  localparam logic [OFS_W-1:0] FULL = '1;

  logic [1:0] flags_s;
  logic       ok;
  logic       ramp_zero;
  phase_e     phase;

  ss_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pgood_i, enable_i}),
    .q_o   (flags_s)
  );

  assign ok = &flags_s;

  ss_phase_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .DISCH_CYCLES (DISCH_CYCLES)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ok_i       (ok),
    .ramp_zero_i(ramp_zero),
    .phase_o    (phase)
  );

  // reload on abort in the same edge the phase drops to hold
  ss_offset_ramp #(.OFS_W(OFS_W)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (!ok || phase == PH_HOLD || phase == PH_SETTLE || phase == PH_DISCH),
    .dec_i   (phase == PH_RAMP),
    .offset_o(offset_o),
    .zero_o  (ramp_zero)
  );

  assign phase_o     = phase;
  assign inhibit_o   = (phase == PH_HOLD);
  assign discharge_o = (phase == PH_DISCH);
  assign switch_en_o = (phase == PH_RAMP) || (phase == PH_RUN);
  assign done_o      = (phase == PH_RUN);

  AST_HOLD_BLOCKS_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o |-> (!switch_en_o && offset_o == FULL)); // R1
  AST_RAMP_ENTRY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase == PH_RAMP) |-> offset_o == FULL); // R5
  AST_DONE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> offset_o == '0); // R6
  AST_EXCLUSIVE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inhibit_o, discharge_o, switch_en_o})); // R4
endmodule

// File: tb/softstart_seq_tb_top.sv
module softstart_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  phase;
  logic        inh, dis, sw, done;
  logic [10:0] ofs;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  softstart_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pgood_i(pg), .enable_i(en),
    .phase_o(phase), .inhibit_o(inh), .discharge_o(dis),
    .switch_en_o(sw), .offset_o(ofs), .done_o(done)
  );

  // behavioural reference
  bit dly[$] = '{1'b0, 1'b0};
  int m_ph = 0, m_cnt = 0, m_ofs = 2047;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly = '{1'b0, 1'b0};
      m_ph = 0; m_cnt = 0; m_ofs = 2047;
    end else begin
      bit qual;
      qual = dly.pop_front();
      dly.push_back(pg && en);
      if (!qual) begin
        m_ph = 0; m_cnt = 0; m_ofs = 2047;
      end else begin
        case (m_ph)
          0: begin m_ph = 1; m_cnt = 0; end
          1: if (m_cnt == 1023) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
          2: if (m_cnt == 23) begin m_ph = 3; m_cnt = 0; end else m_cnt++;
          3: if (m_ofs == 0) m_ph = 4; else m_ofs--;
          default: m_ph = 4;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(phase == 3'(m_ph), "R1", "phase", phase, m_ph);
      chk(inh == (m_ph == 0), "R1", "inhibit", inh, m_ph == 0);
      chk(dis == (m_ph == 2), "R4", "discharge", dis, m_ph == 2);
      chk(sw == (m_ph >= 3), "R5", "switch_en", sw, m_ph >= 3);
      chk(done == (m_ph == 4), "R6", "done", done, m_ph == 4);
      chk(ofs == 11'(m_ofs), "R5", "offset", ofs, m_ofs);
    end
  end

  task automatic drive(input bit p, input bit e);
    @(negedge clk); pg = p; en = e;
  endtask

  task automatic edges_to(input int ph, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (phase != 3'(ph) && n < 5000);
  endtask

  task automatic len_of(input int ph, output int n);
    n = 0;
    while (phase == 3'(ph) && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_phase(input int ph);
    int g = 0;
    while (phase != 3'(ph) && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic abort_in(input int ph, input int after, input bit drop_pg, input string req);
    int n;
    drive(1, 1);
    wait_phase(ph);
    repeat (after) @(negedge clk);
    pg = !drop_pg; en = drop_pg;
    edges_to(0, n);
    chk(n == 3, req, "abort latency", n, 3);
    chk(ofs == 11'd2047 && inh && !sw, req, "state after abort", ofs, 2047);
    repeat (10) @(negedge clk);
    chk(phase == 3'd0, "R2", "stays hold with one input", phase, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(phase == 0 && inh && !sw && !dis && !done && ofs == 11'd2047, "R1", "reset state", phase, 0);
    rst_n = 1'b1;
    drive(1, 0);
    repeat (40) @(negedge clk);
    chk(phase == 0 && inh, "R2", "pgood only", phase, 0);
    drive(0, 1);
    repeat (40) @(negedge clk);
    chk(phase == 0 && inh, "R2", "enable only", phase, 0);
    drive(1, 1);
    edges_to(1, n);
    chk(n == 3, "R8", "sync latency", n, 3);
    len_of(1, n);
    chk(n == 1024, "R3", "settle length", n, 1024);
    chk(dis && phase == 2, "R4", "discharge start", dis, 1);
    len_of(2, n);
    chk(n == 24, "R4", "discharge length", n, 24);
    chk(ofs == 11'd2047 && sw, "R5", "ramp first offset", ofs, 2047);
    len_of(3, n);
    chk(n == 2048, "R5", "ramp length", n, 2048);
    repeat (100) @(negedge clk);
    chk(done && ofs == 0 && phase == 4, "R6", "run holds", phase, 4);
    pg = 1'b0;
    edges_to(0, n);
    chk(n == 3, "R7", "abort from run", n, 3);
    abort_in(1, 500, 1'b0, "R7");
    abort_in(2, 10, 1'b0, "R7");
    abort_in(3, 1000, 1'b1, "R7");
    abort_in(4, 5, 1'b1, "R7");
    drive(1, 1);
    wait_phase(1);
    len_of(1, n);
    chk(n == 1024, "R7", "restart settle length", n, 1024);
    wait_phase(4);
    chk(done && ofs == 0, "R6", "final run", ofs, 0);
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule